// File: doc/BRIEF.md
# Standby Entry and Exit Sequencer

This block puts a processor subsystem into a clock-gated standby state and brings it back out. When the core reports that it has executed its idle instruction, the block keeps the core clock and the peripheral clocks running for a fixed flush window, so the pipeline and any pending transfers can drain. It then gates both clocks off. The enables for the PLL and the watchdog stay asserted the whole time.

A wake input brings the subsystem back. The block can accept it at once, or only after the input has stayed high for a programmable number of cycles. Once the block accepts a wake, it counts down a wake latency whose length depends on where the core resumes from: on-chip RAM, flash that is awake, or flash that is asleep, which is far slower. When the countdown ends, both clocks come back and a one-cycle resume pulse goes out. A wake that arrives during the flush window is held and acted on as soon as standby is reached.

Top module: `lp_standby_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to the running state: `sysclk_en_o`, `periph_clk_en_o`, `pll_en_o` and `wdog_en_o` read 1, while `standby_o` and `resume_o` read 0.
- R2: `idle_req_i` sampled high while running keeps `sysclk_en_o` and `periph_clk_en_o` at 1 for exactly FLUSH_CYCLES (default 32) further cycles. Both then drop to 0 and `standby_o` rises.
- R3: `pll_en_o` and `wdog_en_o` stay at 1 in every state, including standby and the wake countdown.
- R4: With `resume_src_i` = 2'b00 (on-chip RAM) and qualification off, the clocks come back LAT_RAM (default 100) cycles after the edge at which the wake is accepted.
- R5: With `resume_src_i` = 2'b01 (flash awake), the wake latency is LAT_FLASH_ACT (default 100) cycles.
- R6: With `resume_src_i[1]` = 1 (2'b10 or 2'b11, flash asleep), the wake latency is LAT_FLASH_SLP (default 1125) cycles.
- R7: With `qual_en_i` = 1, a wake is accepted only at the qual_len-th consecutive high sample of `wake_i` (a `qual_len_i` of 0 counts as 1). Shorter pulses are ignored. Measured from the first high sample, the latency becomes the memory latency plus `qual_len_i` - 1.
- R8: A wake accepted during the flush window is held. Standby is still entered at the end of the window, and the countdown starts on the next edge.
- R9: `resume_o` is high for exactly one cycle. That is the cycle in which `sysclk_en_o` and `periph_clk_en_o` return to 1, and it follows the last countdown edge.
- R10: `idle_req_i` has no effect outside the running state. `wake_i` has no effect in the running state: no resume pulse, and the clocks stay on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| idle_req_i | input | 1 | Core reports that the idle instruction has executed |
| wake_i | input | 1 | External wake request, active high |
| qual_en_i | input | 1 | 1 = require a stable-high wake of `qual_len_i` cycles |
| qual_len_i | input | QUAL_W | Number of consecutive high samples that qualify a wake |
| resume_src_i | input | 2 | Resume memory: 00 RAM, 01 flash awake, 1x flash asleep |
| sysclk_en_o | output | 1 | Registered core clock enable |
| periph_clk_en_o | output | 1 | Registered peripheral clock enable |
| pll_en_o | output | 1 | PLL enable, held on |
| wdog_en_o | output | 1 | Watchdog clock enable, held on |
| standby_o | output | 1 | High while the clocks are gated (standby and wake countdown) |
| resume_o | output | 1 | One-cycle pulse when execution resumes |

## Verification
The assertions check on every cycle:
- the PLL and watchdog enables never drop;
- the clocks fall only after exactly the flush length of flush cycles;
- the clocks return only together with the resume pulse, and that pulse never lasts two cycles;
- a wake accepted during the flush is held.

Only the bench scenarios can show the exact latency for each resume source, and how a qualified pulse lengthens the latency. The same goes for short qualified pulses being ignored, the total timing of a wake held over from the flush, and idle or wake requests arriving in the wrong state. A cycle-level reference model checks all of these against the outputs.

// File: rtl/lp_stby_pkg.sv
package lp_stby_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_FLUSH   = 2'd1,
    ST_STANDBY = 2'd2,
    ST_WAKE    = 2'd3
  } stby_state_e;

  // Larger of two counts, used to size the shared countdown.
  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Wake latency picked from the resume memory: bit 1 set means flash asleep,
  // otherwise bit 0 set means flash awake, otherwise on-chip RAM.
  function automatic int unsigned wake_latency(logic [1:0] src,
                                               int unsigned ram_lat,
                                               int unsigned act_lat,
                                               int unsigned slp_lat);
    if (src[1])      return slp_lat;
    else if (src[0]) return act_lat;
    else             return ram_lat;
  endfunction

  // Clocks stay enabled while running and during the flush window.
  function automatic logic clocks_on(stby_state_e s);
    return (s == ST_RUN) || (s == ST_FLUSH);
  endfunction

endpackage

// File: rtl/lp_wake_qual.sv
module lp_wake_qual #(
  parameter int unsigned QUAL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake_i,
  input  logic              qual_en_i,
  input  logic [QUAL_W-1:0] qual_len_i,
  output logic              wake_ok_o
);
  localparam logic [QUAL_W-1:0] RUN_MAX = {QUAL_W{1'b1}};

  // Count of consecutive high samples before the current one.
  logic [QUAL_W-1:0] run_q;

  function automatic logic reached(logic [QUAL_W-1:0] prev_run,
                                   logic [QUAL_W-1:0] need);
    logic [QUAL_W:0] need_eff;
    logic [QUAL_W:0] now_run;
    need_eff = (need == '0) ? {{QUAL_W{1'b0}}, 1'b1} : {1'b0, need};
    now_run  = {1'b0, prev_run} + {{QUAL_W{1'b0}}, 1'b1};
    return now_run >= need_eff;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (wake_i) begin
      run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
    end else begin
      run_q <= '0;
    end
  end

  assign wake_ok_o = qual_en_i ? (wake_i && reached(run_q, qual_len_i)) : wake_i;

endmodule

// File: rtl/lp_phase_timer.sv
module lp_phase_timer #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lp_clk_en_reg.sv
module lp_clk_en_reg (
  input  logic clk,
  input  logic rst,
  input  logic clocks_on_i,
  input  logic resume_set_i,
  output logic sysclk_en_o,
  output logic periph_clk_en_o,
  output logic pll_en_o,
  output logic wdog_en_o,
  output logic standby_o,
  output logic resume_o
);
  // Every enable leaves a flop, so decoding the next state cannot glitch it.
  always_ff @(posedge clk) begin
    if (rst) begin
      sysclk_en_o     <= 1'b1;
      periph_clk_en_o <= 1'b1;
      pll_en_o        <= 1'b1;
      wdog_en_o       <= 1'b1;
      standby_o       <= 1'b0;
      resume_o        <= 1'b0;
    end else begin
      sysclk_en_o     <= clocks_on_i;
      periph_clk_en_o <= clocks_on_i;
      pll_en_o        <= 1'b1;
      wdog_en_o       <= 1'b1;
      standby_o       <= !clocks_on_i;
      resume_o        <= resume_set_i;
    end
  end

endmodule

// File: rtl/lp_standby_seq.sv
module lp_standby_seq
  import lp_stby_pkg::*;
#(
  parameter int unsigned FLUSH_CYCLES  = 32,
  parameter int unsigned LAT_RAM       = 100,
  parameter int unsigned LAT_FLASH_ACT = 100,
  parameter int unsigned LAT_FLASH_SLP = 1125,
  parameter int unsigned QUAL_W        = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req_i,
  input  logic              wake_i,
  input  logic              qual_en_i,
  input  logic [QUAL_W-1:0] qual_len_i,
  input  logic [1:0]        resume_src_i,
  output logic              sysclk_en_o,
  output logic              periph_clk_en_o,
  output logic              pll_en_o,
  output logic              wdog_en_o,
  output logic              standby_o,
  output logic              resume_o
);
  localparam int unsigned MAX_SPAN =
    max2(max2(FLUSH_CYCLES, LAT_RAM), max2(LAT_FLASH_ACT, LAT_FLASH_SLP));
  localparam int unsigned CNT_W = $clog2(MAX_SPAN + 1);

  stby_state_e      state_q, state_d;
  logic             wake_pend;     // wake accepted during the flush window
  logic             wake_ok;       // qualified wake this cycle
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             leave_wake;    // countdown over, resume now
  logic             in_flush;
  logic             flush_done;

  lp_wake_qual #(.QUAL_W(QUAL_W)) qual_i (
    .clk        (clk),
    .rst        (rst),
    .wake_i     (wake_i),
    .qual_en_i  (qual_en_i),
    .qual_len_i (qual_len_i),
    .wake_ok_o  (wake_ok)
  );

  lp_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign in_flush   = (state_q == ST_FLUSH);
  assign flush_done = in_flush && tmr_zero;

  always_comb begin
    state_d    = state_q;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    leave_wake = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (idle_req_i) begin
          state_d  = ST_FLUSH;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(FLUSH_CYCLES - 1);
        end
      end
      ST_FLUSH: begin
        if (tmr_zero) state_d = ST_STANDBY;
      end
      ST_STANDBY: begin
        if (wake_ok || wake_pend) begin
          state_d  = ST_WAKE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(wake_latency(resume_src_i, LAT_RAM,
                                         LAT_FLASH_ACT, LAT_FLASH_SLP) - 1);
        end
      end
      ST_WAKE: begin
        if (tmr_zero) begin
          state_d    = ST_RUN;
          leave_wake = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      wake_pend <= 1'b0;
    end else begin
      state_q   <= state_d;
      // Held only through the flush. Standby consumes it on its first edge.
      wake_pend <= in_flush ? (wake_pend | wake_ok) : 1'b0;
    end
  end

  lp_clk_en_reg en_i (
    .clk             (clk),
    .rst             (rst),
    .clocks_on_i     (clocks_on(state_d)),
    .resume_set_i    (leave_wake),
    .sysclk_en_o     (sysclk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .pll_en_o        (pll_en_o),
    .wdog_en_o       (wdog_en_o),
    .standby_o       (standby_o),
    .resume_o        (resume_o)
  );

endmodule

// File: rtl/lp_standby_seq_chk.sv
module lp_standby_seq_chk #(
  parameter int unsigned FLUSH_CYCLES = 32
) (
  input logic clk,
  input logic rst,
  input logic sysclk_en_o,
  input logic periph_clk_en_o,
  input logic pll_en_o,
  input logic wdog_en_o,
  input logic standby_o,
  input logic resume_o,
  input logic in_flush,
  input logic flush_done,
  input logic wake_ok,
  input logic wake_pend
);
  // Counts the cycles spent in the current flush window.
  int unsigned fl_cnt;
  always_ff @(posedge clk) begin
    if (rst || !in_flush) fl_cnt <= 0;
    else                  fl_cnt <= fl_cnt + 1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (sysclk_en_o && periph_clk_en_o && !standby_o && !resume_o));

  assert_pll_wdog_on_R3: assert property (@(posedge clk) disable iff (rst)
    pll_en_o && wdog_en_o);

  assert_gate_after_flush_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sysclk_en_o) |-> (fl_cnt == FLUSH_CYCLES) && $past(flush_done));

  assert_clock_return_with_resume_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(sysclk_en_o)) |-> resume_o && periph_clk_en_o);

  assert_resume_single_R9: assert property (@(posedge clk) disable iff (rst)
    resume_o |=> !resume_o);

  assert_flush_wake_held_R8: assert property (@(posedge clk) disable iff (rst)
    (in_flush && wake_ok) |=> wake_pend);

endmodule

bind lp_standby_seq lp_standby_seq_chk #(.FLUSH_CYCLES(FLUSH_CYCLES)) chk_i (
  .clk             (clk),
  .rst             (rst),
  .sysclk_en_o     (sysclk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .pll_en_o        (pll_en_o),
  .wdog_en_o       (wdog_en_o),
  .standby_o       (standby_o),
  .resume_o        (resume_o),
  .in_flush        (in_flush),
  .flush_done      (flush_done),
  .wake_ok         (wake_ok),
  .wake_pend       (wake_pend)
);

// File: tb/lp_standby_seq_tb_top.sv
module lp_standby_seq_tb_top;
  localparam int FLUSH = 32;
  localparam int L_RAM = 100;
  localparam int L_ACT = 100;
  localparam int L_SLP = 1125;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idle_req = 1'b0;
  logic       wake = 1'b0;
  logic       qen = 1'b0;
  logic [3:0] qlen = 4'd0;
  logic [1:0] src = 2'b00;
  logic sysclk_en, periph_en, pll_en, wdog_en, stby, resume;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // 20-unit period: 50 MHz with 1 ns units.
  always #10 clk = ~clk;

  lp_standby_seq dut_i (
    .clk(clk), .rst(rst), .idle_req_i(idle_req), .wake_i(wake),
    .qual_en_i(qen), .qual_len_i(qlen), .resume_src_i(src),
    .sysclk_en_o(sysclk_en), .periph_clk_en_o(periph_en), .pll_en_o(pll_en),
    .wdog_en_o(wdog_en), .standby_o(stby), .resume_o(resume)
  );

  // Behavioural reference model: 0 run, 1 flush, 2 standby, 3 wake countdown.
  int m_mode = 0, m_rem = 0, m_hi = 0;
  bit m_pend = 0, m_res = 0;

  function automatic int ref_lat(logic [1:0] s);
    if (s == 2'b00) return L_RAM;
    if (s == 2'b01) return L_ACT;
    return L_SLP;
  endfunction

  always @(posedge clk) begin
    int hi_now;
    int need;
    bit ok;
    if (rst) begin
      m_mode = 0; m_hi = 0; m_pend = 0; m_res = 0; m_rem = 0;
    end else begin
      hi_now = wake ? m_hi + 1 : 0;
      need   = (qlen == 0) ? 1 : int'(qlen);
      ok     = qen ? (wake && hi_now >= need) : wake;
      m_res  = 0;
      if (m_mode == 0) begin
        if (idle_req) begin m_mode = 1; m_rem = FLUSH; end
      end else if (m_mode == 1) begin
        if (ok) m_pend = 1;
        m_rem--;
        if (m_rem == 0) m_mode = 2;
      end else if (m_mode == 2) begin
        if (ok || m_pend) begin m_mode = 3; m_rem = ref_lat(src); m_pend = 0; end
      end else begin
        m_rem--;
        if (m_rem == 0) begin m_mode = 0; m_res = 1; end
      end
      m_hi = hi_now;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare the outputs with the model on every cycle, away from the edge.
  always @(negedge clk) begin
    if (!done) begin
      chk(tag, "sysclk_en", int'(sysclk_en), int'(m_mode < 2));
      chk(tag, "periph_en", int'(periph_en), int'(m_mode < 2));
      chk(tag, "standby",   int'(stby),      int'(m_mode >= 2));
      chk(tag, "resume",    int'(resume),    int'(m_res));
      chk("R3", "pll_en",   int'(pll_en),    1);
      chk("R3", "wdog_en",  int'(wdog_en),   1);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Pulse idle and count the cycles for which the clocks stay on.
  task automatic go_standby(output int n);
    @(negedge clk) idle_req = 1'b1;
    @(negedge clk) idle_req = 1'b0;
    n = 0;
    while (sysclk_en && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Hold wake for 'pulse' samples. Return the edges from the first high sample to resume.
  task automatic wake_measure(input int pulse, output int lat);
    int n = 0;
    wake = 1'b1;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n >= pulse) wake = 1'b0;
      if (resume || n > 5000) break;
    end
    wake = 1'b0;
    lat = n - 1;
  endtask

  initial begin
    int n;
    int lat;
    int seen;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: state after reset
    chk("R1", "sysclk after reset", int'(sysclk_en), 1);
    chk("R1", "resume after reset", int'(resume), 0);

    tag = "R2";
    go_standby(n);
    chk("R2", "flush cycles", n, FLUSH);
    chk("R2", "standby raised", int'(stby), 1);

    tag = "R4"; src = 2'b00;
    wake_measure(1, lat);
    chk("R4", "RAM latency", lat, L_RAM);
    // R9: resume coincides with clock return, lasts one cycle
    chk("R9", "clock back with resume", int'(sysclk_en), 1);
    tick(1);
    chk("R9", "resume single cycle", int'(resume), 0);

    tag = "R5"; src = 2'b01;
    go_standby(n);
    wake_measure(2, lat);
    chk("R5", "flash active latency", lat, L_ACT);

    tag = "R6"; src = 2'b10;
    go_standby(n);
    wake_measure(1, lat);
    chk("R6", "flash sleep latency", lat, L_SLP);
    src = 2'b11;
    go_standby(n);
    wake_measure(1, lat);
    chk("R6", "flash sleep latency src 11", lat, L_SLP);

    tag = "R7"; src = 2'b00; qen = 1'b1; qlen = 4'd5;
    go_standby(n);
    wake = 1'b1;
    tick(3);
    wake = 1'b0;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (resume || !stby) seen++;
    end
    chk("R7", "short pulse ignored", seen, 0);
    wake_measure(8, lat);
    chk("R7", "qualified latency", lat, L_RAM + 4);
    qen = 1'b0; qlen = 4'd0;

    tag = "R8";
    n = 0;
    idle_req = 1'b1;
    forever begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1)  idle_req = 1'b0;
      if (n == 10) wake = 1'b1;
      if (n == 11) wake = 1'b0;
      if (resume || n > 5000) break;
    end
    chk("R8", "held wake total", n, FLUSH + 1 + L_RAM + 1);

    tag = "R10";
    wake = 1'b1;
    tick(3);
    wake = 1'b0;
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (resume || !sysclk_en) seen++;
    end
    chk("R10", "wake ignored while running", seen, 0);
    go_standby(n);
    idle_req = 1'b1;
    tick(1);
    idle_req = 1'b0;
    tick(5);
    chk("R10", "idle ignored in standby", int'(sysclk_en), 0);
    wake_measure(1, lat);
    chk("R10", "wake after ignored idle", lat, L_RAM);

    tag = "R1";
    go_standby(n);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    chk("R1", "reset leaves standby", int'(sysclk_en), 1);
    chk("R1", "reset clears standby", int'(stby), 0);
    tick(5);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule